// File: doc/BRIEF.md
# Multi-core CPU release configuration registers

This block is a memory-mapped configuration register window for a cluster of four cores. A simple 32-bit register bus reaches it with separate read and write strobes, a word address inside a 1 KiB window, and write data. The block keeps three writable words: a general control word, a standby flag and a start address used when a core is released. All other registers in the map are fixed. The reset, status and clock-gating registers always read back as released or enabled, the per-core control registers read as zero, and writes to them change nothing.

Its one active function is releasing a core. A nonzero write to a core's reset register produces a single-cycle one-hot request for that core on the following cycle. The core number comes from the register's address. The stored start address and a fixed start privilege level of 3 accompany the request. Accesses to the debug and 64-bit counter slots return zero and raise a "not implemented" pulse. Accesses to holes in the map or to addresses that are not word aligned return zero and raise a separate "bad address" pulse.

Top module: `cpu_launch_cfg`

## Requirements
- R1: After reset the general control word reads 0x00000020, the standby flag reads 0 and the start address reads 0. No launch request, read-valid or error output is active.
- R2: The general control word (offset 0x184), the standby flag (0x1A0) and the start address (0x1A4) keep all 32 bits written to them, and a later read returns them unchanged.
- R3: Fixed reads return the following values. Global reset (0x000) and system reset (0x140) return 0x1. Each core reset register (0x040 + 0x40·n, n = 0..3) returns 0x3. Each core status register (0x048 + 0x40·n) returns 0x1. Clock gating (0x144) returns 0x10F. Each core control register (0x044 + 0x40·n) returns 0.
- R4: Read data and the read-valid output appear on the clock edge after the edge that samples the read strobe. Read-valid is high for exactly one cycle per read.
- R5: A write of a nonzero value to offset 0x040 + 0x40·n sets bit n of the 4-bit launch request (bit 0 = core 0) for exactly one cycle, starting on the edge after the write. Every other bit stays low. The core index is (offset − 0x40) >> 6.
- R6: While a launch request is high, the launch address output equals the stored start address and the launch level output equals 3.
- R7: A write of zero to a core reset register raises no launch request.
- R8: Writes to the global reset, system reset, core control, core status and clock-gating registers raise no launch request. They leave every stored word and every fixed read value unchanged.
- R9: Reads and writes of offsets 0x1E4, 0x280, 0x284 and 0x288 pulse the not-implemented flag for one cycle, on the edge after the access. Reads of these offsets return 0, writes change no stored word, and the bad-address flag stays low.
- R10: An access to any offset outside the map, or with address bits [1:0] nonzero, pulses the bad-address flag for one cycle on the edge after the access. Such a read returns 0. Such a write changes no stored word and raises no launch request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, accepted in the cycle it is high |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Byte offset inside the 1 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| err_unimpl | output | 1 | Pulse: access to a slot that is not implemented |
| err_badaddr | output | 1 | Pulse: access outside the map or misaligned |
| launch_req | output | 4 | One-hot core release request, one-cycle pulse |
| launch_pc | output | 32 | Start address presented with a request |
| launch_level | output | 2 | Start privilege level presented with a request |

## Verification
All results of the block are due one edge after the edge that samples a strobe: read data and read-valid, both error pulses and the launch request. A stored word is visible to a read issued in the next cycle. The bench drives every strobe at a falling edge and keeps it high across exactly one rising edge. It samples the outputs at the next falling edge, where the pulse must be present, and at the falling edge after that, where the pulse must be gone. Each write check therefore covers both the presence of a pulse and its one-cycle length. Writes that must have no effect are followed by read-backs, so that any state they might have disturbed is observed through the bus.

// File: rtl/clc_pkg.sv
package clc_pkg;

  typedef enum logic [3:0] {
    K_GLB_RST,
    K_CORE_RST,
    K_CORE_CTL,
    K_CORE_STS,
    K_SYS_RST,
    K_CLK_GATE,
    K_GEN_CTL,
    K_STANDBY,
    K_ENTRY,
    K_UNIMPL,
    K_BAD
  } reg_kind_e;

  // Register offsets (byte addresses inside the window)
  localparam int unsigned OFS_GLB_RST     = 'h000;
  localparam int unsigned OFS_CORE_BASE   = 'h040;
  localparam int unsigned OFS_CORE_STRIDE = 'h040;
  localparam int unsigned SUB_RST         = 'h0;
  localparam int unsigned SUB_CTL         = 'h4;
  localparam int unsigned SUB_STS         = 'h8;
  localparam int unsigned OFS_SYS_RST     = 'h140;
  localparam int unsigned OFS_CLK_GATE    = 'h144;
  localparam int unsigned OFS_GEN_CTL     = 'h184;
  localparam int unsigned OFS_STANDBY     = 'h1A0;
  localparam int unsigned OFS_ENTRY       = 'h1A4;
  localparam int unsigned OFS_DEBUG       = 'h1E4;
  localparam int unsigned OFS_CNT_CTL     = 'h280;
  localparam int unsigned OFS_CNT_LO      = 'h284;
  localparam int unsigned OFS_CNT_HI      = 'h288;

  // Fixed read values
  localparam logic [31:0] VAL_RST_RELEASED  = 32'h0000_0001;
  localparam logic [31:0] VAL_CORE_RELEASED = 32'h0000_0003;
  localparam logic [31:0] VAL_CORE_SMP      = 32'h0000_0001;
  localparam logic [31:0] VAL_CLK_ENABLED   = 32'h0000_010F;

  // Reset values of stored words
  localparam logic [31:0] RST_GEN_CTL = 32'h0000_0020;

endpackage

// File: rtl/clc_addr_decode.sv
module clc_addr_decode
  import clc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [CORE_W-1:0] core_idx
);

  logic [NUM_CORES-1:0] hit_rst;
  logic [NUM_CORES-1:0] hit_ctl;
  logic [NUM_CORES-1:0] hit_sts;

  for (genvar n = 0; n < NUM_CORES; n++) begin : g_core_hit
    localparam int unsigned BASE_N = OFS_CORE_BASE + OFS_CORE_STRIDE * n;
    assign hit_rst[n] = (addr == ADDR_W'(BASE_N + SUB_RST));
    assign hit_ctl[n] = (addr == ADDR_W'(BASE_N + SUB_CTL));
    assign hit_sts[n] = (addr == ADDR_W'(BASE_N + SUB_STS));
  end

  // Core index of a reset hit: equals (offset - base) / stride
  always_comb begin
    core_idx = '0;
    for (int n = 0; n < NUM_CORES; n++) begin
      if (hit_rst[n]) core_idx = core_idx | CORE_W'(n);
    end
  end

  always_comb begin
    kind = K_BAD;
    if (addr[1:0] != 2'b00) begin
      kind = K_BAD;
    end else if (|hit_rst) begin
      kind = K_CORE_RST;
    end else if (|hit_ctl) begin
      kind = K_CORE_CTL;
    end else if (|hit_sts) begin
      kind = K_CORE_STS;
    end else begin
      case (addr)
        ADDR_W'(OFS_GLB_RST):  kind = K_GLB_RST;
        ADDR_W'(OFS_SYS_RST):  kind = K_SYS_RST;
        ADDR_W'(OFS_CLK_GATE): kind = K_CLK_GATE;
        ADDR_W'(OFS_GEN_CTL):  kind = K_GEN_CTL;
        ADDR_W'(OFS_STANDBY):  kind = K_STANDBY;
        ADDR_W'(OFS_ENTRY):    kind = K_ENTRY;
        ADDR_W'(OFS_DEBUG),
        ADDR_W'(OFS_CNT_CTL),
        ADDR_W'(OFS_CNT_LO),
        ADDR_W'(OFS_CNT_HI):   kind = K_UNIMPL;
        default:               kind = K_BAD;
      endcase
    end
  end

  always_comb begin
    assert ($onehot0({|hit_rst, |hit_ctl, |hit_sts}))
      else $error("AST_CORE_SLOT_UNIQUE"); // R3
  end

endmodule

// File: rtl/clc_cfg_store.sv
module clc_cfg_store #(
  parameter int unsigned      DATA_W  = 32,
  parameter logic [DATA_W-1:0] GEN_RST = DATA_W'(32'h20)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_we,
  input  logic              stby_we,
  input  logic              entry_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] gen_q,
  output logic [DATA_W-1:0] stby_q,
  output logic [DATA_W-1:0] entry_q
);

  logic [DATA_W-1:0] gen_d, stby_d, entry_d;

  always_comb begin
    gen_d   = gen_we   ? wdata : gen_q;
    stby_d  = stby_we  ? wdata : stby_q;
    entry_d = entry_we ? wdata : entry_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q   <= GEN_RST;
      stby_q  <= '0;
      entry_q <= '0;
    end else begin
      gen_q   <= gen_d;
      stby_q  <= stby_d;
      entry_q <= entry_d;
    end
  end

  AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gen_we) |-> $stable(gen_q)) else $error("AST_GEN_HOLD"); // R8
  AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stby_we) |-> $stable(stby_q)) else $error("AST_STBY_HOLD"); // R8
  AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(entry_we) |-> $stable(entry_q)) else $error("AST_ENTRY_HOLD"); // R10

endmodule

// File: rtl/clc_read_mux.sv
module clc_read_mux
  import clc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  reg_kind_e         kind,
  input  logic [DATA_W-1:0] gen_q,
  input  logic [DATA_W-1:0] stby_q,
  input  logic [DATA_W-1:0] entry_q,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    unique case (kind)
      K_GLB_RST,
      K_SYS_RST:   rdata = DATA_W'(VAL_RST_RELEASED);
      K_CORE_RST:  rdata = DATA_W'(VAL_CORE_RELEASED);
      K_CORE_STS:  rdata = DATA_W'(VAL_CORE_SMP);
      K_CLK_GATE:  rdata = DATA_W'(VAL_CLK_ENABLED);
      K_GEN_CTL:   rdata = gen_q;
      K_STANDBY:   rdata = stby_q;
      K_ENTRY:     rdata = entry_q;
      default:     rdata = '0; // core control, unimplemented, bad
    endcase
  end

endmodule

// File: rtl/clc_launch_gen.sv
module clc_launch_gen #(
  parameter int unsigned NUM_CORES   = 4,
  parameter int unsigned CORE_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned LVL_W       = 2,
  parameter int unsigned START_LEVEL = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [CORE_W-1:0]    core_idx,
  input  logic [DATA_W-1:0]    entry_q,
  output logic [NUM_CORES-1:0] launch_req,
  output logic [DATA_W-1:0]    launch_pc,
  output logic [LVL_W-1:0]     launch_level
);

  logic [NUM_CORES-1:0] req_d;

  always_comb begin
    req_d = '0;
    if (fire) req_d = NUM_CORES'(1) << core_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) launch_req <= '0;
    else        launch_req <= req_d;
  end

  assign launch_pc    = entry_q;
  assign launch_level = LVL_W'(START_LEVEL);

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch_req)) else $error("AST_REQ_ONEHOT"); // R5
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|launch_req) |-> $past(fire)) else $error("AST_REQ_CAUSE"); // R5
  AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (|launch_req) |-> (launch_pc == $past(entry_q))) else $error("AST_PC_HELD"); // R6

endmodule

// File: rtl/cpu_launch_cfg.sv
module cpu_launch_cfg
  import clc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_CORES   = 4,
  parameter int unsigned LVL_W       = 2,
  parameter int unsigned START_LEVEL = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  output logic                 err_unimpl,
  output logic                 err_badaddr,
  output logic [NUM_CORES-1:0] launch_req,
  output logic [DATA_W-1:0]    launch_pc,
  output logic [LVL_W-1:0]     launch_level
);

  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  reg_kind_e         kind;
  logic [CORE_W-1:0] core_idx;
  logic [DATA_W-1:0] gen_q, stby_q, entry_q;
  logic [DATA_W-1:0] rdata_d;
  logic              gen_we, stby_we, entry_we, fire;
  logic              access;

  clc_addr_decode #(.ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_decode (
    .addr     (bus_addr),
    .kind     (kind),
    .core_idx (core_idx)
  );

  always_comb begin
    gen_we   = bus_wr && (kind == K_GEN_CTL);
    stby_we  = bus_wr && (kind == K_STANDBY);
    entry_we = bus_wr && (kind == K_ENTRY);
    fire     = bus_wr && (kind == K_CORE_RST) && (bus_wdata != '0);
    access   = bus_wr || bus_rd;
  end

  clc_cfg_store #(.DATA_W(DATA_W), .GEN_RST(DATA_W'(RST_GEN_CTL))) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_we   (gen_we),
    .stby_we  (stby_we),
    .entry_we (entry_we),
    .wdata    (bus_wdata),
    .gen_q    (gen_q),
    .stby_q   (stby_q),
    .entry_q  (entry_q)
  );

  clc_read_mux #(.DATA_W(DATA_W)) u_rmux (
    .kind    (kind),
    .gen_q   (gen_q),
    .stby_q  (stby_q),
    .entry_q (entry_q),
    .rdata   (rdata_d)
  );

  clc_launch_gen #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .DATA_W(DATA_W),
    .LVL_W(LVL_W), .START_LEVEL(START_LEVEL)
  ) u_launch (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (fire),
    .core_idx     (core_idx),
    .entry_q      (entry_q),
    .launch_req   (launch_req),
    .launch_pc    (launch_pc),
    .launch_level (launch_level)
  );

  // Bus response registers
  logic [DATA_W-1:0] rdata_nx;
  logic              rvalid_nx, unimpl_nx, bad_nx;

  always_comb begin
    rdata_nx  = bus_rd ? rdata_d : bus_rdata;
    rvalid_nx = bus_rd;
    unimpl_nx = access && (kind == K_UNIMPL);
    bad_nx    = access && (kind == K_BAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata   <= '0;
      bus_rvalid  <= 1'b0;
      err_unimpl  <= 1'b0;
      err_badaddr <= 1'b0;
    end else begin
      bus_rdata   <= rdata_nx;
      bus_rvalid  <= rvalid_nx;
      err_unimpl  <= unimpl_nx;
      err_badaddr <= bad_nx;
    end
  end

  AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd)) else $error("AST_RVALID_CAUSE"); // R4
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_unimpl && err_badaddr)) else $error("AST_ERR_EXCL"); // R9
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && err_badaddr) |-> (bus_rdata == '0)) else $error("AST_BAD_READ_ZERO"); // R10
  AST_UNIMPL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && err_unimpl) |-> (bus_rdata == '0)) else $error("AST_UNIMPL_READ_ZERO"); // R9

endmodule

// File: tb/cpu_launch_cfg_tb_top.sv
`timescale 1ns/1ps
module cpu_launch_cfg_tb_top;

  logic        clk;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, err_unimpl, err_badaddr;
  logic [3:0]  launch_req;
  logic [31:0] launch_pc;
  logic [1:0]  launch_level;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  cpu_launch_cfg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .err_unimpl(err_unimpl), .err_badaddr(err_badaddr),
    .launch_req(launch_req), .launch_pc(launch_pc), .launch_level(launch_level)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Observations
  logic [3:0]  o_req, o_req2;
  logic [31:0] o_pc, o_data;
  logic [1:0]  o_lvl;
  logic        o_unimpl, o_bad, o_valid, o_valid2, o_err2;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    o_req = launch_req; o_pc = launch_pc; o_lvl = launch_level;
    o_unimpl = err_unimpl; o_bad = err_badaddr;
    @(negedge clk);
    o_req2 = launch_req;
    o_err2 = err_unimpl | err_badaddr;
  endtask

  task automatic do_read(input logic [9:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    o_valid = bus_rvalid; o_data = bus_rdata;
    o_unimpl = err_unimpl; o_bad = err_badaddr;
    @(negedge clk);
    o_valid2 = bus_rvalid;
    o_err2 = err_unimpl | err_badaddr;
  endtask

  task automatic t_reset_state;
    chk("R1", "launch_req idle", {28'd0, launch_req}, 32'd0);
    chk("R1", "rvalid idle", {31'd0, bus_rvalid}, 32'd0);
    chk("R1", "errors idle", {30'd0, err_unimpl, err_badaddr}, 32'd0);
    do_read(10'h184); chk("R1", "gen ctl reset", o_data, 32'h20);
    do_read(10'h1A0); chk("R1", "standby reset", o_data, 32'h0);
    do_read(10'h1A4); chk("R1", "entry reset", o_data, 32'h0);
  endtask

  task automatic t_rw_words;
    do_write(10'h184, 32'hA5A5_5A5A);
    do_write(10'h1A0, 32'hFFFF_FFFF);
    do_write(10'h1A4, 32'h8000_1000);
    do_read(10'h184); chk("R2", "gen ctl readback", o_data, 32'hA5A5_5A5A);
    do_read(10'h1A0); chk("R2", "standby readback", o_data, 32'hFFFF_FFFF);
    do_read(10'h1A4); chk("R2", "entry readback", o_data, 32'h8000_1000);
    do_write(10'h1A0, 32'h0000_0001);
    do_read(10'h1A0); chk("R2", "standby second value", o_data, 32'h1);
  endtask

  task automatic t_fixed_reads;
    do_read(10'h000); chk("R3", "global reset", o_data, 32'h1);
    chk("R4", "rvalid after read", {31'd0, o_valid}, 32'd1);
    chk("R4", "rvalid one cycle", {31'd0, o_valid2}, 32'd0);
    do_read(10'h140); chk("R3", "system reset", o_data, 32'h1);
    do_read(10'h144); chk("R3", "clock gating", o_data, 32'h10F);
    for (int n = 0; n < 4; n++) begin
      do_read(10'(32'h40 + 32'h40 * n)); chk("R3", "core reset reg", o_data, 32'h3);
      do_read(10'(32'h44 + 32'h40 * n)); chk("R3", "core control reg", o_data, 32'h0);
      do_read(10'(32'h48 + 32'h40 * n)); chk("R3", "core status reg", o_data, 32'h1);
      chk("R4", "fixed read valid", {31'd0, o_valid}, 32'd1);
    end
  endtask

  task automatic t_launch;
    do_write(10'h1A4, 32'h4000_0200);
    for (int n = 0; n < 4; n++) begin
      do_write(10'(32'h40 + 32'h40 * n), (n == 2) ? 32'h3 : 32'h1);
      chk("R5", "launch one-hot", {28'd0, o_req}, 32'(1) << n);
      chk("R5", "launch single cycle", {28'd0, o_req2}, 32'd0);
      chk("R6", "launch pc", o_pc, 32'h4000_0200);
      chk("R6", "launch level", {30'd0, o_lvl}, 32'd3);
    end
    do_write(10'h1A4, 32'hDEAD_BEE0);
    do_write(10'h100, 32'h8000_0000);
    chk("R5", "core 3 after new entry", {28'd0, o_req}, 32'h8);
    chk("R6", "pc follows new entry", o_pc, 32'hDEAD_BEE0);
  endtask

  task automatic t_launch_zero;
    for (int n = 0; n < 4; n++) begin
      do_write(10'(32'h40 + 32'h40 * n), 32'h0);
      chk("R7", "zero write no launch", {28'd0, o_req | o_req2}, 32'd0);
    end
  endtask

  task automatic t_ignored_writes;
    do_write(10'h184, 32'h1234_5678);
    do_write(10'h1A0, 32'h0000_0000);
    do_write(10'h000, 32'hFFFF_FFFF);
    chk("R8", "global reset write no launch", {28'd0, o_req}, 32'd0);
    do_write(10'h140, 32'hFFFF_FFFF);
    chk("R8", "sys reset write no launch", {28'd0, o_req}, 32'd0);
    do_write(10'h144, 32'h0);
    do_write(10'h0C4, 32'hFFFF_FFFF);
    chk("R8", "core ctl write no launch", {28'd0, o_req}, 32'd0);
    do_write(10'h048, 32'hFFFF_FFFF);
    chk("R8", "core sts write no launch", {28'd0, o_req}, 32'd0);
    do_read(10'h144); chk("R8", "clock gating unchanged", o_data, 32'h10F);
    do_read(10'h0C4); chk("R8", "core ctl still zero", o_data, 32'h0);
    do_read(10'h048); chk("R8", "core sts unchanged", o_data, 32'h1);
    do_read(10'h000); chk("R8", "global reset unchanged", o_data, 32'h1);
    do_read(10'h184); chk("R8", "gen ctl unchanged", o_data, 32'h1234_5678);
    do_read(10'h1A0); chk("R8", "standby unchanged", o_data, 32'h0);
    do_read(10'h1A4); chk("R8", "entry unchanged", o_data, 32'hDEAD_BEE0);
  endtask

  task automatic t_unimpl;
    logic [9:0] slots [4] = '{10'h1E4, 10'h280, 10'h284, 10'h288};
    for (int i = 0; i < 4; i++) begin
      do_read(slots[i]);
      chk("R9", "unimpl read data", o_data, 32'h0);
      chk("R9", "unimpl flag", {30'd0, o_unimpl, o_bad}, 32'h2);
      chk("R9", "unimpl flag one cycle", {31'd0, o_err2}, 32'd0);
    end
    do_write(10'h280, 32'hFFFF_FFFF);
    chk("R9", "unimpl write flag", {30'd0, o_unimpl, o_bad}, 32'h2);
    do_read(10'h1A4); chk("R9", "entry unchanged after unimpl", o_data, 32'hDEAD_BEE0);
  endtask

  task automatic t_badaddr;
    logic [9:0] holes [4] = '{10'h3FC, 10'h046, 10'h10C, 10'h1A8};
    for (int i = 0; i < 4; i++) begin
      do_read(holes[i]);
      chk("R10", "bad read data", o_data, 32'h0);
      chk("R10", "bad flag", {30'd0, o_unimpl, o_bad}, 32'h1);
      chk("R10", "bad flag one cycle", {31'd0, o_err2}, 32'd0);
    end
    do_write(10'h041, 32'h1);
    chk("R10", "misaligned reset write flag", {30'd0, o_unimpl, o_bad}, 32'h1);
    chk("R10", "misaligned reset write no launch", {28'd0, o_req | o_req2}, 32'd0);
    do_write(10'h1A6, 32'h0);
    chk("R10", "misaligned entry write flag", {31'd0, o_bad}, 32'd1);
    do_read(10'h1A4); chk("R10", "entry unchanged after bad", o_data, 32'hDEAD_BEE0);
  endtask

  initial begin
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_rw_words();
    t_fixed_reads();
    t_launch();
    t_launch_zero();
    t_ignored_writes();
    t_unimpl();
    t_badaddr();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule